// File: doc/BRIEF.md
# Privilege-Gated Auxiliary Event Counter Bank

This block holds a bank of sixteen 64-bit auxiliary event counter slots, of which a parameter selects how many exist and which of them are built. Each built counter advances by one on every clock in which both its enable and its event input are high. Software reaches the counters through a coprocessor-style access port. A request carries a 4-bit slot number, the requester's privilege level (0 to 3) and a read or write flag. For a write, it also carries two 32-bit data words.

Every request is decoded against a fixed priority chain, and one of four outcomes comes back one cycle later: a successful transfer, a forced-zero read, a trap to a named higher level with a syndrome code, or undefined. Reads from levels 0 and 1 can optionally see the physical count minus a per-counter 64-bit offset. The offsets are loaded through a separate offset load port. Only the highest privilege level may write a counter. A write aimed at a running counter is dropped and sets a sticky error flag, which keeps the outcome deterministic.

Top module: `evtmon_bank`

## Requirements
- R1: A request's slot number is idx = {req_crm_b0, req_opc1[2:0]}. One cycle after a request, rsp_valid is high. A successful read returns count bits 31:0 on rsp_rt and bits 63:32 on rsp_rt2, taken from the value the counter held in the request cycle.
- R2: A request is UNDEF when idx >= NUM_IMPL or when IMPL_MASK[idx] is 0. The defaults are 12 and 16'h0FDF, so slots 5 and 12 to 15 are undefined. This check outranks every other rule.
- R3: A read from level 0 with cfg_user_en low traps to level 1. When cfg_host_route is high, it traps to level 2 instead. This is the first check after R2.
- R4: When cfg_upper_trap is high, an access to slots 8 to 15 traps to level 2. This applies to reads from levels 0 and 1, and to writes from level 1.
- R5: After R3 and R4, a read from level 0 or 1 traps to level 2 when cfg_trap_l2 is high. Otherwise, a read from levels 0 to 2 traps to level 3 when cfg_trap_l3 is high. A read from level 3 never traps.
- R6: A read that passes R2 to R5 from a level other than 3 returns status ZERO with all-zero data when cfg_rd_zero is high.
- R7: A successful read from level 0 or 1 returns the count minus the slot's offset, modulo 2^64, when cfg_voff_l2 and cfg_voff_l3 are both high. Reads from levels 2 and 3 return the physical count. An offset is loaded by voff_we with voff_sel and voff_val.
- R8: A write from level 3 that passes R2 and R4 returns OK and loads the counter with {req_rt2, req_rt}. A write from any other level that passes R2 and R4 is UNDEF and leaves the counter unchanged.
- R9: A built counter increments by one on each clock where cnt_en and evt_in for that slot are both high. It wraps from all-ones to zero.
- R10: A level-3 write to a slot whose cnt_en is high returns OK, leaves the count unchanged, and sets wr_err. wr_err then stays high until reset.
- R11: rsp_status encodes OK=0, ZERO=1, TRAP=2, UNDEF=3. On TRAP, rsp_tgt gives the target level and rsp_syndrome is 6'h04. Otherwise both are zero. rsp_rt and rsp_rt2 are zero for every outcome except a successful read. After reset, rsp_valid and wr_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 16 | Per-slot count enable |
| evt_in | input | 16 | Per-slot event input |
| cfg_upper_trap | input | 1 | Trap slots 8 to 15 to level 2 |
| cfg_trap_l3 | input | 1 | Trap reads from levels 0 to 2 to level 3 |
| cfg_trap_l2 | input | 1 | Trap reads from levels 0 and 1 to level 2 |
| cfg_user_en | input | 1 | Allow level 0 reads |
| cfg_host_route | input | 1 | Route level 0 user trap to level 2 |
| cfg_rd_zero | input | 1 | Force zero reads below level 3 |
| cfg_voff_l2 | input | 1 | Offset enable, first control |
| cfg_voff_l3 | input | 1 | Offset enable, second control |
| voff_we | input | 1 | Load an offset |
| voff_sel | input | 4 | Offset slot to load |
| voff_val | input | 64 | Offset value |
| req_valid | input | 1 | Access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_el | input | 2 | Requester privilege level |
| req_opc1 | input | 3 | Low three bits of the slot number |
| req_crm_b0 | input | 1 | High bit of the slot number |
| req_rt | input | 32 | Write data, low half |
| req_rt2 | input | 32 | Write data, high half |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | Outcome code |
| rsp_tgt | output | 2 | Trap target level |
| rsp_syndrome | output | 6 | Trap syndrome |
| rsp_rt | output | 32 | Read data, low half |
| rsp_rt2 | output | 32 | Read data, high half |
| wr_err | output | 1 | Sticky write-while-enabled error |

## Verification
The hardest situations to reach are those where several gating controls are active at once. The outcome then depends only on which rule ranks first, for example an unbuilt slot read at level 0 with every trap bit set, or an upper-group access that could also be caught by the level-2 or level-3 trap. The stimulus layers directed cases, which switch on all competing controls together, under a long seeded random run. That random run re-draws every control bit, level, slot and direction on each access while counters tick underneath. The wrap case is reached by loading all-ones at level 3 and then giving a single counted event.

// File: rtl/evtmon_pkg.sv
// Shared types for the event counter bank: outcome codes, the access
// control bundle and fixed constants. Assumes a 16-slot index space.
package evtmon_pkg;
    localparam int SLOTS = 16;
    localparam int IDX_W = 4;
    localparam logic [5:0] TRAP_SYN = 6'h04;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_ZERO  = 2'd1,
        ST_TRAP  = 2'd2,
        ST_UNDEF = 2'd3
    } acc_status_e;

    typedef struct packed {
        logic upper_trap;
        logic trap_l3;
        logic trap_l2;
        logic user_en;
        logic host_route;
        logic rd_zero;
        logic voff_l2;
        logic voff_l3;
    } acc_cfg_t;
endpackage

// File: rtl/evtmon_counter.sv
// One counter slot: loads a value or advances by one per qualified cycle.
// Assumes ld and inc are never both meaningful (the top drops loads to
// enabled counters), but load still takes precedence if they coincide.
module evtmon_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt
);
    // Count register: reset, load, or increment modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/evtmon_voff.sv
// Per-slot offset store with one load port and one combinational read.
// HAS_VOFF = 0 builds no storage and reads as zero.
module evtmon_voff #(
    parameter int CNT_W    = 64,
    parameter bit HAS_VOFF = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [evtmon_pkg::IDX_W-1:0] sel,
    input  logic [CNT_W-1:0]             val,
    input  logic [evtmon_pkg::IDX_W-1:0] rd_sel,
    output logic [CNT_W-1:0]             rd_off
);
    import evtmon_pkg::*;

    generate
        if (HAS_VOFF) begin : g_store
            logic [CNT_W-1:0] off_q [SLOTS];
            // Offset registers: cleared on reset, one slot loaded per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < SLOTS; s++) off_q[s] <= '0;
                end else if (we) begin
                    off_q[sel] <= val;
                end
            end
            assign rd_off = off_q[rd_sel];
        end else begin : g_none
            logic unused;
            assign unused = &{1'b0, clk, rst_n, we, sel, val, rd_sel};
            assign rd_off = '0;
        end
    endgenerate
endmodule

// File: rtl/evtmon_decode.sv
// Combinational access decoder. Applies the fixed priority chain to one
// request and reports outcome, trap level, whether to subtract the offset
// and whether a write may proceed. Highest privilege level is 3.
module evtmon_decode #(
    parameter int                            NUM_IMPL   = 12,
    parameter logic [evtmon_pkg::SLOTS-1:0]  IMPL_MASK  = 16'h0FDF,
    parameter int                            UPPER_BASE = 8,
    parameter bit                            HAS_VOFF   = 1'b1
) (
    input  logic [evtmon_pkg::IDX_W-1:0] idx,
    input  logic [1:0]                   el,
    input  logic                         wr,
    input  evtmon_pkg::acc_cfg_t         cfg,
    output evtmon_pkg::acc_status_e      status,
    output logic [1:0]                   tgt,
    output logic                         sub_off,
    output logic                         wr_ok
);
    import evtmon_pkg::*;

    localparam logic [1:0] TOP_EL = 2'd3;

    logic built;
    logic upper;
    logic low_el;

    assign built  = (int'(idx) < NUM_IMPL) && IMPL_MASK[idx];
    assign upper  = (int'(idx) >= UPPER_BASE);
    assign low_el = (el <= 2'd1);

    // Priority chain: existence, then traps, then zero/offset/physical.
    always_comb begin
        status  = ST_OK;
        tgt     = 2'd0;
        sub_off = 1'b0;
        wr_ok   = 1'b0;
        if (!built) begin
            status = ST_UNDEF;
        end else if (wr) begin
            if (el == 2'd1 && upper && cfg.upper_trap) begin
                status = ST_TRAP;
                tgt    = 2'd2;
            end else if (el == TOP_EL) begin
                wr_ok  = 1'b1;
            end else begin
                status = ST_UNDEF;
            end
        end else if (el == 2'd0 && !cfg.user_en) begin
            status = ST_TRAP;
            tgt    = cfg.host_route ? 2'd2 : 2'd1;
        end else if (low_el && upper && cfg.upper_trap) begin
            status = ST_TRAP;
            tgt    = 2'd2;
        end else if (low_el && cfg.trap_l2) begin
            status = ST_TRAP;
            tgt    = 2'd2;
        end else if (el != TOP_EL && cfg.trap_l3) begin
            status = ST_TRAP;
            tgt    = 2'd3;
        end else if (el != TOP_EL && cfg.rd_zero) begin
            status = ST_ZERO;
        end else begin
            sub_off = HAS_VOFF && low_el && cfg.voff_l2 && cfg.voff_l3;
        end
    end
endmodule

// File: rtl/evtmon_bank.sv
// Top of the privilege-gated event counter bank. Builds the counters that
// IMPL_MASK and NUM_IMPL select, decodes each access and registers the
// response one cycle after the request. Writes to running counters are
// dropped and flagged in a sticky error bit.
module evtmon_bank #(
    parameter int                           NUM_IMPL   = 12,
    parameter logic [evtmon_pkg::SLOTS-1:0] IMPL_MASK  = 16'h0FDF,
    parameter int                           CNT_W      = 64,
    parameter int                           UPPER_BASE = 8,
    parameter bit                           HAS_VOFF   = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [evtmon_pkg::SLOTS-1:0] cnt_en,
    input  logic [evtmon_pkg::SLOTS-1:0] evt_in,
    input  logic                         cfg_upper_trap,
    input  logic                         cfg_trap_l3,
    input  logic                         cfg_trap_l2,
    input  logic                         cfg_user_en,
    input  logic                         cfg_host_route,
    input  logic                         cfg_rd_zero,
    input  logic                         cfg_voff_l2,
    input  logic                         cfg_voff_l3,
    input  logic                         voff_we,
    input  logic [evtmon_pkg::IDX_W-1:0] voff_sel,
    input  logic [CNT_W-1:0]             voff_val,
    input  logic                         req_valid,
    input  logic                         req_wr,
    input  logic [1:0]                   req_el,
    input  logic [2:0]                   req_opc1,
    input  logic                         req_crm_b0,
    input  logic [CNT_W/2-1:0]           req_rt,
    input  logic [CNT_W/2-1:0]           req_rt2,
    output logic                         rsp_valid,
    output logic [1:0]                   rsp_status,
    output logic [1:0]                   rsp_tgt,
    output logic [5:0]                   rsp_syndrome,
    output logic [CNT_W/2-1:0]           rsp_rt,
    output logic [CNT_W/2-1:0]           rsp_rt2,
    output logic                         wr_err
);
    import evtmon_pkg::*;

    localparam int HALF_W = CNT_W / 2;

    logic [IDX_W-1:0] idx;
    acc_cfg_t         cfg;
    acc_status_e      dec_status;
    logic [1:0]       dec_tgt;
    logic             dec_sub;
    logic             dec_wr_ok;
    logic [CNT_W-1:0] cnt_q [SLOTS];
    logic [CNT_W-1:0] sel_cnt;
    logic [CNT_W-1:0] sel_off;
    logic [CNT_W-1:0] rd_val;
    logic             wr_go;

    assign idx = {req_crm_b0, req_opc1};
    assign cfg = '{upper_trap: cfg_upper_trap, trap_l3: cfg_trap_l3,
                   trap_l2: cfg_trap_l2, user_en: cfg_user_en,
                   host_route: cfg_host_route, rd_zero: cfg_rd_zero,
                   voff_l2: cfg_voff_l2, voff_l3: cfg_voff_l3};

    evtmon_decode #(
        .NUM_IMPL  (NUM_IMPL),
        .IMPL_MASK (IMPL_MASK),
        .UPPER_BASE(UPPER_BASE),
        .HAS_VOFF  (HAS_VOFF)
    ) u_decode (
        .idx    (idx),
        .el     (req_el),
        .wr     (req_wr),
        .cfg    (cfg),
        .status (dec_status),
        .tgt    (dec_tgt),
        .sub_off(dec_sub),
        .wr_ok  (dec_wr_ok)
    );

    assign wr_go = req_valid && req_wr && dec_wr_ok;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            if (IMPL_MASK[s] && (s < NUM_IMPL)) begin : g_built
                evtmon_counter #(.CNT_W(CNT_W)) u_cnt (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .inc   (cnt_en[s] && evt_in[s]),
                    .ld    (wr_go && (idx == s) && !cnt_en[s]),
                    .ld_val({req_rt2, req_rt}),
                    .cnt   (cnt_q[s])
                );
            end else begin : g_absent
                assign cnt_q[s] = '0;
            end
        end
    endgenerate

    evtmon_voff #(.CNT_W(CNT_W), .HAS_VOFF(HAS_VOFF)) u_voff (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (voff_we),
        .sel   (voff_sel),
        .val   (voff_val),
        .rd_sel(idx),
        .rd_off(sel_off)
    );

    assign sel_cnt = cnt_q[idx];
    assign rd_val  = dec_sub ? (sel_cnt - sel_off) : sel_cnt;

    // Response register: outcome and read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid    <= 1'b0;
            rsp_status   <= ST_OK;
            rsp_tgt      <= 2'd0;
            rsp_syndrome <= 6'd0;
            rsp_rt       <= '0;
            rsp_rt2      <= '0;
        end else begin
            rsp_valid    <= 1'b1;
            rsp_status   <= dec_status;
            rsp_tgt      <= dec_tgt;
            rsp_syndrome <= (dec_status == ST_TRAP) ? TRAP_SYN : 6'd0;
            if (!req_wr && dec_status == ST_OK) begin
                rsp_rt  <= rd_val[HALF_W-1:0];
                rsp_rt2 <= rd_val[CNT_W-1:HALF_W];
            end else begin
                rsp_rt  <= '0;
                rsp_rt2 <= '0;
            end
        end
    end

    // Sticky error: a permitted write hit a counter that was running.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wr_err <= 1'b0;
        else if (wr_go && cnt_en[idx])  wr_err <= 1'b1;
    end
endmodule

// File: rtl/evtmon_chk.sv
// Checker for evtmon_bank: port-level temporal properties on the access
// outcome. Attached to every instance of the top by the bind below.
module evtmon_chk #(
    parameter int                           NUM_IMPL  = 12,
    parameter logic [evtmon_pkg::SLOTS-1:0] IMPL_MASK = 16'h0FDF,
    parameter int                           HALF_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_wr,
    input logic [1:0]        req_el,
    input logic [2:0]        req_opc1,
    input logic              req_crm_b0,
    input logic              cfg_user_en,
    input logic              cfg_host_route,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic [1:0]        rsp_tgt,
    input logic [5:0]        rsp_syndrome,
    input logic [HALF_W-1:0] rsp_rt,
    input logic [HALF_W-1:0] rsp_rt2,
    input logic              wr_err
);
    logic [3:0] c_idx;
    logic       c_built;
    assign c_idx   = {req_crm_b0, req_opc1};
    assign c_built = (int'(c_idx) < NUM_IMPL) && IMPL_MASK[c_idx];

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2
    undef_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !c_built |=> rsp_status == 2'd3);
    // R3
    user_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_wr && req_el == 2'd0 && c_built && !cfg_user_en
        |=> rsp_status == 2'd2 && rsp_tgt == ($past(cfg_host_route) ? 2'd2 : 2'd1));
    // R8
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_wr && req_el == 2'd0 && c_built |=> rsp_status == 2'd3);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);
    // R11
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status != 2'd0 |-> rsp_rt == '0 && rsp_rt2 == '0);
    // R11
    trap_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status == 2'd2 |-> rsp_syndrome == 6'h04 && rsp_tgt != 2'd0);
endmodule

bind evtmon_bank evtmon_chk #(
    .NUM_IMPL (NUM_IMPL),
    .IMPL_MASK(IMPL_MASK),
    .HALF_W   (CNT_W/2)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_wr        (req_wr),
    .req_el        (req_el),
    .req_opc1      (req_opc1),
    .req_crm_b0    (req_crm_b0),
    .cfg_user_en   (cfg_user_en),
    .cfg_host_route(cfg_host_route),
    .rsp_valid     (rsp_valid),
    .rsp_status    (rsp_status),
    .rsp_tgt       (rsp_tgt),
    .rsp_syndrome  (rsp_syndrome),
    .rsp_rt        (rsp_rt),
    .rsp_rt2       (rsp_rt2),
    .wr_err        (wr_err)
);

// File: tb/evtmon_bank_bench.sv
`timescale 1ns/1ps
module evtmon_bank_bench;
    localparam int          N_IMPL = 12;
    localparam logic [15:0] MASK   = 16'h0FDF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [15:0] cnt_en = '0, evt_in = '0;
    logic c_up = 0, c_t3 = 0, c_t2 = 0, c_ue = 1, c_host = 0, c_rz = 0, c_v2 = 0, c_v3 = 0;
    logic        voff_we = 0;
    logic [3:0]  voff_sel = '0;
    logic [63:0] voff_val = '0;
    logic        req_valid = 0, req_wr = 0, req_crm_b0 = 0;
    logic [1:0]  req_el = '0;
    logic [2:0]  req_opc1 = '0;
    logic [31:0] req_rt = '0, req_rt2 = '0;
    logic        rsp_valid, wr_err;
    logic [1:0]  rsp_status, rsp_tgt;
    logic [5:0]  rsp_syndrome;
    logic [31:0] rsp_rt, rsp_rt2;

    int n_chk = 0, n_bad = 0;

    evtmon_bank #(.NUM_IMPL(N_IMPL), .IMPL_MASK(MASK)) u_evtmon_bank (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .evt_in(evt_in),
        .cfg_upper_trap(c_up), .cfg_trap_l3(c_t3), .cfg_trap_l2(c_t2),
        .cfg_user_en(c_ue), .cfg_host_route(c_host), .cfg_rd_zero(c_rz),
        .cfg_voff_l2(c_v2), .cfg_voff_l3(c_v3),
        .voff_we(voff_we), .voff_sel(voff_sel), .voff_val(voff_val),
        .req_valid(req_valid), .req_wr(req_wr), .req_el(req_el),
        .req_opc1(req_opc1), .req_crm_b0(req_crm_b0),
        .req_rt(req_rt), .req_rt2(req_rt2),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_tgt(rsp_tgt),
        .rsp_syndrome(rsp_syndrome), .rsp_rt(rsp_rt), .rsp_rt2(rsp_rt2),
        .wr_err(wr_err)
    );

    // Reference state, advanced on each clock from the bench's own drives.
    logic [63:0] m_cnt [16];
    logic [63:0] m_off [16];
    logic        m_err;
    logic        ld_pend = 0, err_pend = 0;
    logic [3:0]  ld_slot = '0;
    logic [63:0] ld_val = '0;

    function automatic logic built(input logic [3:0] i);
        return (int'(i) < N_IMPL) && MASK[i];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 16; s++) begin m_cnt[s] <= '0; m_off[s] <= '0; end
            m_err <= 1'b0;
        end else begin
            for (int s = 0; s < 16; s++)
                if (ld_pend && ld_slot == s) m_cnt[s] <= ld_val;
                else if (cnt_en[s] && evt_in[s] && built(4'(s))) m_cnt[s] <= m_cnt[s] + 64'd1;
            if (voff_we) m_off[voff_sel] <= voff_val;
            if (err_pend) m_err <= 1'b1;
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected outcome from the requirements, using the bench model.
    task automatic predict(input logic wr, input logic [1:0] el, input logic [3:0] idx,
                           output logic [1:0] st, output logic [1:0] tg,
                           output logic [63:0] dat, output logic ok_wr, output string tag);
        logic up;
        logic lo;
        up = idx >= 4'd8;
        lo = el <= 2'd1;
        st = 2'd0; tg = 2'd0; dat = '0; ok_wr = 1'b0;
        if (!built(idx)) begin st = 2'd3; tag = "R2"; end
        else if (wr) begin
            if (el == 2'd1 && up && c_up) begin st = 2'd2; tg = 2'd2; tag = "R4"; end
            else if (el == 2'd3) begin ok_wr = 1'b1; tag = cnt_en[idx] ? "R10" : "R8"; end
            else begin st = 2'd3; tag = "R8"; end
        end
        else if (el == 2'd0 && !c_ue) begin st = 2'd2; tg = c_host ? 2'd2 : 2'd1; tag = "R3"; end
        else if (lo && up && c_up) begin st = 2'd2; tg = 2'd2; tag = "R4"; end
        else if (lo && c_t2) begin st = 2'd2; tg = 2'd2; tag = "R5"; end
        else if (el != 2'd3 && c_t3) begin st = 2'd2; tg = 2'd3; tag = "R5"; end
        else if (el != 2'd3 && c_rz) begin st = 2'd1; tag = "R6"; end
        else if (lo && c_v2 && c_v3) begin dat = m_cnt[idx] - m_off[idx]; tag = "R7"; end
        else begin dat = m_cnt[idx]; tag = "R1"; end
    endtask

    task automatic access(input logic wr, input logic [1:0] el, input logic [3:0] idx,
                          input logic [63:0] wd);
        logic [1:0] st, tg;
        logic [63:0] dat;
        logic okw;
        string tag;
        @(negedge clk);
        req_valid = 1; req_wr = wr; req_el = el;
        req_crm_b0 = idx[3]; req_opc1 = idx[2:0];
        req_rt = wd[31:0]; req_rt2 = wd[63:32];
        predict(wr, el, idx, st, tg, dat, okw, tag);
        ld_pend = okw && !cnt_en[idx]; ld_slot = idx; ld_val = wd;
        err_pend = okw && cnt_en[idx];
        @(negedge clk);
        req_valid = 0; ld_pend = 0; err_pend = 0;
        check(tag, "valid", 64'(rsp_valid), 64'd1);
        check(tag, "status", 64'(rsp_status), 64'(st));
        check(tag, "target", 64'(rsp_tgt), 64'(tg));
        check("R11", "syndrome", 64'(rsp_syndrome), (st == 2'd2) ? 64'h4 : 64'h0);
        check(tag, "data {rt2,rt}", {rsp_rt2, rsp_rt}, dat);
        check("R10", "wr_err", 64'(wr_err), 64'(m_err));
    endtask

    task automatic load_off(input logic [3:0] s, input logic [63:0] v);
        @(negedge clk);
        voff_we = 1; voff_sel = s; voff_val = v;
        @(negedge clk);
        voff_we = 0;
    endtask

    task automatic clear_cfg();
        c_up = 0; c_t3 = 0; c_t2 = 0; c_ue = 1; c_host = 0; c_rz = 0; c_v2 = 0; c_v3 = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        check("R11", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R11", "wr_err after reset", 64'(wr_err), 64'd0);
        access(0, 2'd3, 4'd0, '0);                         // R1 zero count
        // R8 / R1: level-3 load then split readback
        access(1, 2'd3, 4'd3, 64'hAABBCCDD_11223344);
        access(0, 2'd3, 4'd3, '0);
        check("R1", "low half", 64'(rsp_rt), 64'h11223344);
        check("R1", "high half", 64'(rsp_rt2), 64'hAABBCCDD);
        access(1, 2'd1, 4'd3, 64'h5);                      // R8 undef
        access(1, 2'd2, 4'd3, 64'h5);                      // R8 undef
        access(0, 2'd3, 4'd3, '0);                         // R8 unchanged
        // R2: unbuilt slots outrank all traps
        c_up = 1; c_t3 = 1; c_t2 = 1; c_ue = 0;
        access(0, 2'd0, 4'd5, '0);
        access(0, 2'd3, 4'd12, '0);
        access(1, 2'd3, 4'd15, 64'h1);
        clear_cfg();
        // R3: user-enable trap routing
        c_ue = 0; c_t3 = 1;
        access(0, 2'd0, 4'd1, '0);
        c_host = 1;
        access(0, 2'd0, 4'd1, '0);
        clear_cfg();
        // R4: upper group
        c_up = 1; c_t3 = 1;
        access(0, 2'd1, 4'd9, '0);
        access(0, 2'd1, 4'd7, '0);
        access(1, 2'd1, 4'd9, 64'h7);
        access(0, 2'd2, 4'd9, '0);
        clear_cfg();
        // R5: level-2 and level-3 trap controls
        c_t2 = 1;
        access(0, 2'd2, 4'd2, '0);
        access(0, 2'd0, 4'd2, '0);
        c_t3 = 1;
        access(0, 2'd2, 4'd2, '0);
        access(0, 2'd3, 4'd2, '0);
        clear_cfg();
        // R6: read-as-zero
        c_rz = 1;
        access(0, 2'd2, 4'd3, '0);
        access(0, 2'd3, 4'd3, '0);
        clear_cfg();
        // R7: offset subtraction, including an offset larger than the count
        load_off(4'd3, 64'h10);
        c_v2 = 1; c_v3 = 1;
        access(0, 2'd1, 4'd3, '0);
        access(0, 2'd2, 4'd3, '0);
        load_off(4'd4, 64'h20);
        access(0, 2'd0, 4'd4, '0);
        c_v3 = 0;
        access(0, 2'd1, 4'd3, '0);
        clear_cfg();
        // R9: counting and wrap
        access(1, 2'd3, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk); cnt_en[1] = 1; evt_in[1] = 1;
        @(negedge clk); cnt_en[1] = 0; evt_in[1] = 0;
        access(0, 2'd3, 4'd1, '0);
        check("R9", "wrap to zero", {rsp_rt2, rsp_rt}, 64'd0);
        @(negedge clk); cnt_en[2] = 1; evt_in[2] = 1;
        repeat (10) @(negedge clk);
        cnt_en[2] = 0; evt_in[2] = 0;
        access(0, 2'd3, 4'd2, '0);
        check("R9", "ten events", {rsp_rt2, rsp_rt}, 64'd10);
        // R10: write to a running counter is dropped and flagged
        cnt_en[6] = 1;
        access(1, 2'd3, 4'd6, 64'h1234);
        check("R10", "wr_err set", 64'(wr_err), 64'd1);
        cnt_en[6] = 0;
        access(0, 2'd3, 4'd6, '0);
        // Random phase
        for (int k = 0; k < 2000; k++) begin
            logic [3:0] ri;
            logic [1:0] re;
            logic rw;
            c_up = ($urandom % 5) == 0; c_t3 = ($urandom % 5) == 0;
            c_t2 = ($urandom % 5) == 0; c_ue = ($urandom % 5) != 0;
            c_host = $urandom % 2; c_rz = ($urandom % 5) == 0;
            c_v2 = $urandom % 2; c_v3 = $urandom % 2;
            cnt_en = 16'($urandom) & 16'($urandom);
            evt_in = 16'($urandom);
            if (($urandom % 16) == 0) load_off(4'($urandom), {$urandom, $urandom});
            ri = 4'($urandom); re = 2'($urandom); rw = ($urandom % 4) == 0;
            if (rw && ($urandom % 2)) re = 2'd3;
            access(rw, re, ri, {$urandom, $urandom});
        end
        finish_run();
    end
endmodule